// File: doc/BRIEF.md
# Boot Mode Entry Sequence Detector

This block sits beside the core's reset logic and decides, each time the external reset pin is released, whether the core starts at its ordinary reset vector or at the bootloader vector. It watches two asynchronous pins: the active-low reset pin and a test/clock pin. Both pins are brought into the clock domain through synchronizer flops. While the reset pin is held low, the block counts qualifying edges on the test/clock pin. When reset rises, it issues exactly one single-cycle pulse, either `start_boot` or `start_user`.

A parameter picks the pin arrangement. In the shared-pin arrangement (`DEDICATED = 0`), the qualifying edges are rising edges, and the pin must be high at release. In the dedicated-pin arrangement (`DEDICATED = 1`), the polarity is inverted: the qualifying edges are falling edges, and the pin must be low at release. Inside the block this is handled as one "active level", the pin itself or its inverse.

Timing limits are given in nanoseconds. They are turned into cycle counts using the clock frequency parameter `CLK_KHZ`:

- `PIN_MIN_NS` is the minimum time any pin state must last.
- `PIN_EN_NS` is the minimum length of the first active phase.

Three side inputs can refuse bootloader entry and force the ordinary vector:

- the debug port owning the device;
- the reset pin being set to NMI mode;
- a power-on reset.

These control pins are plain levels and pulses. No part of the block is a data stream, so no valid/ready handshake applies.

Top module: `boot_entry_detect`

## Requirements
- R1: With `DEDICATED = 0`, a hold period (reset pin low) that contains two or more qualifying rising edges of `pin_test`, followed by a release with `pin_test` high, produces one `start_boot` pulse and no `start_user` pulse.
- R2: If `pin_test` is at its inactive level when the reset pin rises, `start_user` pulses, whatever number of edges was seen.
- R3: A hold period with fewer than `EDGES_NEEDED` (default 2) qualifying edges produces `start_user`, even with the active level present at release.
- R4: With `DEDICATED = 1`, falling edges of `pin_test` qualify and a low level is required at release; a rising-edge pattern that is high at release produces `start_user`.
- R5: If `dbg_owns` or `nmi_mode` is high in the cycle the release is seen, `start_user` pulses instead of `start_boot`.
- R6: A `por_event` pulse since the previous release forces the next release to `start_user`; the release after that is decided normally.
- R7: An active phase shorter than `PIN_EN_NS` (the first phase of a hold period) or `PIN_MIN_NS` (later phases) is not an edge, and an inactive glitch shorter than `PIN_MIN_NS` does not split one active phase into two.
- R8: The edge count is cleared on every falling edge of the reset pin and saturates at `EDGES_NEEDED`; edges from an earlier hold period never count toward a later one.
- R9: Each reset-pin release yields exactly one output pulse, one clock wide, and `start_boot` and `start_user` are never high together.
- R10: While `rst_n` is low and directly after it, both outputs are low; a reset pin that is already high at that time produces no pulse.
- R11: Edges on `pin_test` while the reset pin is high are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Block reset, active low, synchronous |
| pin_rst_n | input | 1 | Asynchronous external reset pin, low = hold |
| pin_test | input | 1 | Asynchronous test (shared) or clock (dedicated) pin |
| dbg_owns | input | 1 | Debug port owns the device; refuses entry |
| nmi_mode | input | 1 | Reset pin configured as NMI; refuses entry |
| por_event | input | 1 | One-cycle power-on reset indication |
| start_boot | output | 1 | One-cycle pulse: start at bootloader vector |
| start_user | output | 1 | One-cycle pulse: start at ordinary reset vector |

## Verification
The assertions assume that `dbg_owns` and `nmi_mode` are already synchronous to `clk` and steady around a release. They also assume that the two pins never change within a few cycles of each other in a way that lets a qualifying edge and a reset-pin edge fall into the same cycle. The directed stimulus meets both assumptions:

- It changes the side inputs only while the reset pin has long been steady.
- It keeps every deliberate pin state either well above the minimum times, or (for the filter tests) well below them.
- It waits many cycles after the last edge before releasing the reset pin.

The bench drives a shared-pin instance and a dedicated-pin instance. The dedicated instance gets the inverted test pin, so both should decide alike. One scenario drops the inversion to show the polarity difference.

// File: rtl/boot_entry_pkg.sv
package boot_entry_pkg;

  // Ceiling conversion of a time in ns to clock cycles, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned khz, input int unsigned ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(khz) * longint'(ns);
    cyc  = (prod + 64'd999999) / 64'd1000000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [1:0] {
    VEC_NONE = 2'd0,
    VEC_USER = 2'd1,
    VEC_BOOT = 2'd2
  } vec_sel_e;

endpackage

// File: rtl/boot_pin_sync.sv
module boot_pin_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_async,
  output logic [WIDTH-1:0] pins_sync
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{INIT[g]}};
      else        chain <= {chain[STAGES-2:0], pins_async[g]};
    end
    assign pins_sync[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/boot_level_qual.sv
module boot_level_qual #(
  parameter int unsigned FIRST_CYC = 4,
  parameter int unsigned NEXT_CYC  = 2,
  parameter int unsigned FALL_CYC  = 2,
  parameter int unsigned CW        = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic first,
  output logic qual,
  output logic rise
);

  logic [CW-1:0] run;
  logic [CW-1:0] thr;

  // Hysteresis: the filtered level follows the input only after it has
  // differed for the current threshold number of cycles.
  always_comb begin
    if (qual)       thr = CW'(FALL_CYC);
    else if (first) thr = CW'(FIRST_CYC);
    else            thr = CW'(NEXT_CYC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual <= 1'b0;
      run  <= '0;
      rise <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (lvl == qual) begin
        run <= '0;
      end else if (run == thr - CW'(1)) begin
        qual <= lvl;
        run  <= '0;
        rise <= lvl;
      end else begin
        run <= run + CW'(1);
      end
    end
  end

endmodule

// File: rtl/boot_edge_tally.sv
module boot_edge_tally #(
  parameter int unsigned NEED = 2,
  parameter int unsigned ECW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           hold,
  input  logic           rise,
  output logic [ECW-1:0] cnt,
  output logic           full,
  output logic           empty
);

  assign full  = (cnt == ECW'(NEED));
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (hold && rise && !full) cnt <= cnt + ECW'(1);
  end

endmodule

// File: rtl/boot_vector_select.sv
module boot_vector_select
  import boot_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rel,
  input  logic act_lvl,
  input  logic full,
  input  logic dbg_owns,
  input  logic nmi_mode,
  input  logic por_event,
  output logic start_boot,
  output logic start_user
);

  logic     por_seen;
  vec_sel_e sel;

  always_comb begin
    sel = VEC_NONE;
    if (rel) begin
      if (act_lvl && full && !dbg_owns && !nmi_mode && !por_seen && !por_event)
        sel = VEC_BOOT;
      else
        sel = VEC_USER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      por_seen   <= 1'b0;
      start_boot <= 1'b0;
      start_user <= 1'b0;
    end else begin
      start_boot <= (sel == VEC_BOOT);
      start_user <= (sel == VEC_USER);
      if (rel)            por_seen <= 1'b0;
      else if (por_event) por_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/boot_entry_detect.sv
module boot_entry_detect
  import boot_entry_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 125000,
  parameter int unsigned PIN_MIN_NS   = 250,
  parameter int unsigned PIN_EN_NS    = 1000,
  parameter int unsigned EDGES_NEEDED = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          DEDICATED    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rst_n,
  input  logic pin_test,
  input  logic dbg_owns,
  input  logic nmi_mode,
  input  logic por_event,
  output logic start_boot,
  output logic start_user
);

  localparam int unsigned MIN_CYC = ns_to_cyc(CLK_KHZ, PIN_MIN_NS);
  localparam int unsigned EN_CYC  = ns_to_cyc(CLK_KHZ, PIN_EN_NS);
  localparam int unsigned CW      = $clog2(max2(MIN_CYC, EN_CYC) + 1);
  localparam int unsigned ECW     = $clog2(EDGES_NEEDED + 1);
  localparam logic [1:0]  SYNC_INIT = {DEDICATED, 1'b1};

  logic [1:0]     pins_s;
  logic           rst_s, tst_s, rst_p;
  logic           rst_fall, rst_rise;
  logic           act_lvl, qual, rise;
  logic [ECW-1:0] edge_cnt;
  logic           cnt_full, cnt_empty;

  boot_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins_async({pin_test, pin_rst_n}),
    .pins_sync(pins_s)
  );

  assign rst_s = pins_s[0];
  assign tst_s = pins_s[1];

  always_ff @(posedge clk) begin
    if (!rst_n) rst_p <= 1'b1;
    else        rst_p <= rst_s;
  end

  assign rst_fall = rst_p & ~rst_s;
  assign rst_rise = ~rst_p & rst_s;

  if (DEDICATED) begin : g_ded
    assign act_lvl = ~tst_s;
  end else begin : g_shr
    assign act_lvl = tst_s;
  end

  boot_level_qual #(.FIRST_CYC(EN_CYC), .NEXT_CYC(MIN_CYC), .FALL_CYC(MIN_CYC), .CW(CW)) u_qual (
    .clk(clk), .rst_n(rst_n), .lvl(act_lvl), .first(cnt_empty),
    .qual(qual), .rise(rise)
  );

  boot_edge_tally #(.NEED(EDGES_NEEDED), .ECW(ECW)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(rst_fall), .hold(~rst_s), .rise(rise),
    .cnt(edge_cnt), .full(cnt_full), .empty(cnt_empty)
  );

  boot_vector_select u_sel (
    .clk(clk), .rst_n(rst_n), .rel(rst_rise), .act_lvl(act_lvl), .full(cnt_full),
    .dbg_owns(dbg_owns), .nmi_mode(nmi_mode), .por_event(por_event),
    .start_boot(start_boot), .start_user(start_user)
  );

endmodule

// File: rtl/boot_entry_chk.sv
module boot_entry_chk #(
  parameter int unsigned EDGES_NEEDED = 2,
  parameter int unsigned ECW          = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_boot,
  input logic           start_user,
  input logic           dbg_owns,
  input logic           nmi_mode,
  input logic           rst_s,
  input logic [ECW-1:0] edge_cnt
);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_boot && start_user));

  a_r9_boot_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_boot |=> !start_boot);

  a_r9_user_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_user |=> !start_user);

  a_r9_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    (start_boot || start_user) |-> ($past(rst_s) && !$past(rst_s, 2)));

  a_r3_boot_needs_edges: assert property (@(posedge clk) disable iff (!rst_n)
    start_boot |-> (edge_cnt == ECW'(EDGES_NEEDED)));

  a_r5_boot_not_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
    start_boot |-> (!$past(dbg_owns) && !$past(nmi_mode)));

  a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= ECW'(EDGES_NEEDED));

  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_s) |=> (edge_cnt == '0));

endmodule

bind boot_entry_detect boot_entry_chk #(.EDGES_NEEDED(EDGES_NEEDED), .ECW(ECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_boot(start_boot), .start_user(start_user),
  .dbg_owns(dbg_owns), .nmi_mode(nmi_mode), .rst_s(rst_s), .edge_cnt(edge_cnt)
);

// File: tb/boot_entry_detect_bench.sv
module boot_entry_detect_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_rst_n = 1'b1;
  logic test_pin = 1'b0;
  logic invert_b = 1'b1;
  logic dbg_owns = 1'b0;
  logic nmi_mode = 1'b0;
  logic por_event = 1'b0;
  logic tck_pin;
  logic boot_a, user_a, boot_b, user_b;

  int n_checks = 0;
  int n_fail = 0;
  int cnt_boot_a = 0, cnt_user_a = 0, cnt_boot_b = 0, cnt_user_b = 0;
  int both_high = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign tck_pin = invert_b ? ~test_pin : test_pin;

  boot_entry_detect #(.DEDICATED(1'b0)) u_boot_entry_detect (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .pin_test(test_pin),
    .dbg_owns(dbg_owns), .nmi_mode(nmi_mode), .por_event(por_event),
    .start_boot(boot_a), .start_user(user_a)
  );

  boot_entry_detect #(.DEDICATED(1'b1)) u_boot_entry_detect_ded (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .pin_test(tck_pin),
    .dbg_owns(dbg_owns), .nmi_mode(nmi_mode), .por_event(por_event),
    .start_boot(boot_b), .start_user(user_b)
  );

  always @(posedge clk) begin
    cycles++;
    if (boot_a) cnt_boot_a++;
    if (user_a) cnt_user_a++;
    if (boot_b) cnt_boot_b++;
    if (user_b) cnt_user_b++;
    if ((boot_a && user_a) || (boot_b && user_b)) both_high++;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait (cycles >= 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cycles);
    finish_run();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold_start();
    pin_rst_n = 1'b0;
    cyc(40);
  endtask

  task automatic pulse(input int hi, input int lo);
    test_pin = 1'b1; cyc(hi);
    test_pin = 1'b0; cyc(lo);
  endtask

  task automatic release_check(input string req, input int eba, input int eua,
                               input int ebb, input int eub);
    cnt_boot_a = 0; cnt_user_a = 0; cnt_boot_b = 0; cnt_user_b = 0;
    pin_rst_n = 1'b1;
    cyc(12);
    chk({req, " boot shared"}, cnt_boot_a, eba);
    chk({req, " user shared"}, cnt_user_a, eua);
    chk({req, " boot dedicated"}, cnt_boot_b, ebb);
    chk({req, " user dedicated"}, cnt_user_b, eub);
    test_pin = 1'b0;
    cyc(60);
  endtask

  // valid entry: two long active phases, active at release
  task automatic full_entry();
    pulse(250, 50);
    test_pin = 1'b1; cyc(250);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R10 boot low in reset", int'(boot_a | boot_b), 0);
    chk("R10 user low in reset", int'(user_a | user_b), 0);
    rst_n = 1'b1;
    cnt_boot_a = 0; cnt_user_a = 0; cnt_boot_b = 0; cnt_user_b = 0;
    cyc(20);
    chk("R10 no pulse after reset", cnt_boot_a + cnt_user_a + cnt_boot_b + cnt_user_b, 0);
  endtask

  task automatic t_boot();
    hold_start(); full_entry();
    release_check("R1 R4 R9 valid entry", 1, 0, 1, 0);
  endtask

  task automatic t_low_at_release();
    hold_start(); pulse(250, 50); pulse(250, 50);
    release_check("R2 inactive at release", 0, 1, 0, 1);
  endtask

  task automatic t_one_edge();
    hold_start(); test_pin = 1'b1; cyc(250);
    release_check("R3 one edge", 0, 1, 0, 1);
    hold_start();
    release_check("R3 no edge", 0, 1, 0, 1);
  endtask

  task automatic t_filters();
    hold_start(); pulse(62, 50); test_pin = 1'b1; cyc(250);
    release_check("R7 short first phase", 0, 1, 0, 1);
    hold_start(); pulse(250, 50); pulse(12, 50); test_pin = 1'b1; cyc(20);
    release_check("R7 short later phase", 0, 1, 0, 1);
    hold_start(); pulse(250, 10); test_pin = 1'b1; cyc(250);
    release_check("R7 inactive glitch", 0, 1, 0, 1);
  endtask

  task automatic t_fresh_count();
    hold_start(); pulse(250, 50); pulse(250, 50);
    release_check("R8 first hold", 0, 1, 0, 1);
    hold_start(); test_pin = 1'b1; cyc(250);
    release_check("R8 count restarted", 0, 1, 0, 1);
  endtask

  task automatic t_edges_outside_hold();
    pulse(250, 50); pulse(250, 50);
    test_pin = 1'b1; cyc(250);
    hold_start(); cyc(100);
    release_check("R11 edges before hold", 0, 1, 0, 1);
  endtask

  task automatic t_inhibits();
    dbg_owns = 1'b1;
    hold_start(); full_entry();
    release_check("R5 debug owns", 0, 1, 0, 1);
    dbg_owns = 1'b0;
    nmi_mode = 1'b1;
    hold_start(); full_entry();
    release_check("R5 nmi mode", 0, 1, 0, 1);
    nmi_mode = 1'b0;
    cyc(10);
  endtask

  task automatic t_por();
    hold_start();
    por_event = 1'b1; cyc(1); por_event = 1'b0;
    full_entry();
    release_check("R6 por refuses", 0, 1, 0, 1);
    hold_start(); full_entry();
    release_check("R6 next release normal", 1, 0, 1, 0);
  endtask

  task automatic t_polarity();
    invert_b = 1'b0;
    cyc(60);
    hold_start(); full_entry();
    release_check("R4 rising pattern on dedicated", 1, 0, 0, 1);
    test_pin = 1'b0;
    invert_b = 1'b1;
    cyc(60);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_low_at_release();
    t_one_edge();
    t_filters();
    t_fresh_count();
    t_edges_outside_hold();
    t_inhibits();
    t_por();
    t_polarity();
    t_boot();
    chk("R9 outputs never high together", both_high, 0);
    finish_run();
  end

endmodule